// File: doc/BRIEF.md
# DMA Command Condition Selector

This block sits beside the command engine of a descriptor-driven DMA channel and decides, for every command the channel runs, whether the command should raise an interrupt, take a branch, or hold the channel in a wait state. Software programs three selectors, one for interrupt, one for branch and one for wait. Each selector is a pair of 8-bit fields: a mask and a compare value. A selector's condition is true when the channel's 8 device-dependent status bits, ANDed with the mask, equal the compare value.

Each command supplies a 2-bit condition code for each of the three actions. The code picks how the action follows its selector's condition: never, only when the condition is true, only when it is false, or always. The engine marks the start and the completion of each command with single-cycle strobes. At completion the interrupt and branch decisions are registered and come out as one-cycle pulses. A taken branch also sets a sticky branch-taken status bit, which clears when the next command starts. The wait output is a level. It tracks the wait decision while a command is in progress.

Top module: `dma_cond_sel`

## Requirements
- R1: After reset, irqPulse, branchTaken, waitReq and brStatusBit are 0, and all three selectors hold mask 0 and value 0, so every condition reads true.
- R2: Each selector is independent. Its condition is true exactly when (devStatus & mask) == value, and the test uses only that selector's own mask and value.
- R3: Each per-action code is encoded as follows: 0 never fires, 1 fires when the condition is true, 2 fires when the condition is false, 3 always fires.
- R4: When cmdDone is high in a cycle, irqPulse and branchTaken carry that cycle's interrupt and branch decisions in the following cycle only, for exactly one cycle. Without cmdDone, both stay 0.
- R5: brStatusBit is set in the cycle after a completion whose branch is taken. It holds its value until a cycle in which cmdStart is high, and is 0 in the cycle after that. A taken branch has priority if cmdStart and cmdDone coincide.
- R6: A selector write uses selWrSel: 0 writes the interrupt selector, 1 the branch selector, 2 the wait selector. Code 3 writes nothing. A write is seen by evaluations from the next cycle on. A completion in the same cycle as a write uses the old contents.
- R7: waitReq in cycle t+1 is the wait decision on devStatus in cycle t, provided a command was in progress in cycle t and cmdDone was low in that cycle. A command is in progress from the cycle after cmdStart up to and including its cmdDone cycle. Otherwise waitReq is 0, so it drops one cycle after the status stops matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| selWrEn | input | 1 | Selector write strobe |
| selWrSel | input | 2 | Selector select: 0 interrupt, 1 branch, 2 wait, 3 none |
| selWrMask | input | 8 | Mask written to the selected selector |
| selWrValue | input | 8 | Compare value written to the selected selector |
| devStatus | input | 8 | Device-dependent channel status bits |
| cmdStart | input | 1 | Single-cycle strobe: a command begins |
| cmdDone | input | 1 | Single-cycle strobe: the current command completes |
| cmdIntCode | input | 2 | Interrupt condition code of the current command |
| cmdBrCode | input | 2 | Branch condition code of the current command |
| cmdWaitCode | input | 2 | Wait condition code of the current command |
| irqPulse | output | 1 | One-cycle interrupt request after completion |
| branchTaken | output | 1 | One-cycle branch-taken pulse after completion |
| waitReq | output | 1 | Wait level while the command is in progress |
| brStatusBit | output | 1 | Sticky branch-taken channel status bit |

## Verification
The properties assume that cmdStart and cmdDone are single-cycle strobes. They also assume that the command codes and devStatus are stable at the clock edge where cmdDone is sampled. The bench drives every input on the falling edge and pulses each strobe for exactly one cycle. It never raises cmdStart and cmdDone together. It holds the codes constant for the whole of a command, so the completion decision and the wait level always see settled inputs.

// File: rtl/dma_cond_pkg.sv
package dma_cond_pkg;
  localparam int STAT_W  = 8;
  localparam int NUM_SEL = 3;
  localparam int SEL_IRQ  = 0;
  localparam int SEL_BR   = 1;
  localparam int SEL_WAIT = 2;

  typedef enum logic [1:0] {
    CC_NEVER    = 2'd0,
    CC_IF_TRUE  = 2'd1,
    CC_IF_FALSE = 2'd2,
    CC_ALWAYS   = 2'd3
  } condCode_e;

  typedef struct packed {
    logic [STAT_W-1:0] mask;
    logic [STAT_W-1:0] value;
  } selector_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_SEL-1:0] selWr;
  } dpStrobe_t;

  function automatic logic applyCode(logic [1:0] code, logic hit);
    case (condCode_e'(code))
      CC_NEVER:    applyCode = 1'b0;
      CC_IF_TRUE:  applyCode = hit;
      CC_IF_FALSE: applyCode = ~hit;
      default:     applyCode = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/dma_cond_datapath.sv
module dma_cond_datapath
  import dma_cond_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  dpStrobe_t          strobe,
  input  logic [STAT_W-1:0]  wrMask,
  input  logic [STAT_W-1:0]  wrValue,
  input  logic [STAT_W-1:0]  devStatus,
  output logic [NUM_SEL-1:0] condHit
);
  selector_t selReg [NUM_SEL];

  for (genvar s = 0; s < NUM_SEL; s++) begin : g_sel
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        selReg[s] <= '0;
      end else if (strobe.selWr[s]) begin
        selReg[s].mask  <= wrMask;
        selReg[s].value <= wrValue;
      end
    end
    assign condHit[s] = ((devStatus & selReg[s].mask) == selReg[s].value);
  end
endmodule

// File: rtl/dma_cond_ctrl.sv
module dma_cond_ctrl
  import dma_cond_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               selWrEn,
  input  logic [1:0]         selWrSel,
  input  logic               cmdStart,
  input  logic               cmdDone,
  input  logic [1:0]         cmdIntCode,
  input  logic [1:0]         cmdBrCode,
  input  logic [1:0]         cmdWaitCode,
  input  logic [NUM_SEL-1:0] condHit,
  output dpStrobe_t          strobe,
  output logic               irqPulse,
  output logic               branchTaken,
  output logic               waitReq,
  output logic               brStatusBit
);
  logic cmdActive;
  logic irqNext, brNext, waitNext;

  always_comb begin
    strobe = '0;
    for (int s = 0; s < NUM_SEL; s++) begin
      strobe.selWr[s] = selWrEn && (selWrSel == 2'(s));
    end
  end

  assign irqNext  = cmdDone && applyCode(cmdIntCode, condHit[SEL_IRQ]);
  assign brNext   = cmdDone && applyCode(cmdBrCode, condHit[SEL_BR]);
  assign waitNext = cmdActive && !cmdDone && applyCode(cmdWaitCode, condHit[SEL_WAIT]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmdActive   <= 1'b0;
      irqPulse    <= 1'b0;
      branchTaken <= 1'b0;
      waitReq     <= 1'b0;
      brStatusBit <= 1'b0;
    end else begin
      if (cmdStart)     cmdActive <= 1'b1;
      else if (cmdDone) cmdActive <= 1'b0;
      irqPulse    <= irqNext;
      branchTaken <= brNext;
      waitReq     <= waitNext;
      if (brNext)        brStatusBit <= 1'b1;
      else if (cmdStart) brStatusBit <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_cond_sel.sv
module dma_cond_sel
  import dma_cond_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              selWrEn,
  input  logic [1:0]        selWrSel,
  input  logic [STAT_W-1:0] selWrMask,
  input  logic [STAT_W-1:0] selWrValue,
  input  logic [STAT_W-1:0] devStatus,
  input  logic              cmdStart,
  input  logic              cmdDone,
  input  logic [1:0]        cmdIntCode,
  input  logic [1:0]        cmdBrCode,
  input  logic [1:0]        cmdWaitCode,
  output logic              irqPulse,
  output logic              branchTaken,
  output logic              waitReq,
  output logic              brStatusBit
);
  dpStrobe_t          strobe;
  logic [NUM_SEL-1:0] condHit;

  dma_cond_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .wrMask(selWrMask), .wrValue(selWrValue),
    .devStatus(devStatus), .condHit(condHit)
  );

  dma_cond_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .selWrEn(selWrEn), .selWrSel(selWrSel),
    .cmdStart(cmdStart), .cmdDone(cmdDone),
    .cmdIntCode(cmdIntCode), .cmdBrCode(cmdBrCode), .cmdWaitCode(cmdWaitCode),
    .condHit(condHit), .strobe(strobe),
    .irqPulse(irqPulse), .branchTaken(branchTaken),
    .waitReq(waitReq), .brStatusBit(brStatusBit)
  );
endmodule

// File: rtl/dma_cond_sel_chk.sv
module dma_cond_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmdStart,
  input logic       cmdDone,
  input logic [1:0] cmdIntCode,
  input logic [1:0] cmdBrCode,
  input logic       irqPulse,
  input logic       branchTaken,
  input logic       waitReq,
  input logic       brStatusBit
);
  AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irqPulse |-> $past(cmdDone)); // R4
  AST_BR_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    branchTaken |-> $past(cmdDone)); // R4
  AST_NEVER_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdDone && cmdIntCode == 2'd0) |=> !irqPulse); // R3
  AST_ALWAYS_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdDone && cmdBrCode == 2'd3) |=> (branchTaken && brStatusBit)); // R3
  AST_BIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdStart && !cmdDone) |=> !brStatusBit); // R5
  AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmdStart && !cmdDone) |=> $stable(brStatusBit)); // R5
  AST_NO_WAIT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cmdDone |=> !waitReq); // R7
endmodule

bind dma_cond_sel dma_cond_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmdStart(cmdStart), .cmdDone(cmdDone),
  .cmdIntCode(cmdIntCode), .cmdBrCode(cmdBrCode),
  .irqPulse(irqPulse), .branchTaken(branchTaken),
  .waitReq(waitReq), .brStatusBit(brStatusBit)
);

// File: tb/dma_cond_sel_tb_top.sv
module dma_cond_sel_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic selWrEn = 0;
  logic [1:0] selWrSel = 0;
  logic [7:0] selWrMask = 0, selWrValue = 0, devStatus = 0;
  logic cmdStart = 0, cmdDone = 0;
  logic [1:0] cmdIntCode = 0, cmdBrCode = 0, cmdWaitCode = 0;
  logic irqPulse, branchTaken, waitReq, brStatusBit;

  int testsRun = 0;
  int testsFailed = 0;

  typedef struct { logic irq; logic br; } expItem_t;
  expItem_t expQ[$];

  logic [7:0] shMask [3];
  logic [7:0] shVal  [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_cond_sel dut_i (.*);

  task automatic chk(string req, logic act, logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic logic decide(logic [1:0] code, int sel, logic [7:0] st);
    logic hit;
    hit = ((st & shMask[sel]) == shVal[sel]);
    case (code)
      2'd0: decide = 1'b0;
      2'd1: decide = hit;
      2'd2: decide = ~hit;
      default: decide = 1'b1;
    endcase
  endfunction

  task automatic writeSel(logic [1:0] sel, logic [7:0] m, logic [7:0] v);
    @(negedge clk);
    selWrEn = 1; selWrSel = sel; selWrMask = m; selWrValue = v;
    @(negedge clk);
    selWrEn = 0;
    if (sel != 2'd3) begin shMask[sel] = m; shVal[sel] = v; end
  endtask

  task automatic runCmd(logic [1:0] ic, logic [1:0] bc, logic [1:0] wc,
                        logic [7:0] st, int hold);
    @(negedge clk);
    cmdIntCode = ic; cmdBrCode = bc; cmdWaitCode = wc; devStatus = st;
    cmdStart = 1;
    @(negedge clk);
    cmdStart = 0;
    chk("R5 bit cleared by start", brStatusBit, 1'b0);
    for (int i = 0; i < hold; i++) @(negedge clk);
    if (hold > 0) chk("R7 wait level", waitReq, decide(wc, 2, st));
    expQ.push_back('{irq: decide(ic, 0, st), br: decide(bc, 1, st)});
    cmdDone = 1;
    @(negedge clk);
    cmdDone = 0;
  endtask

  // monitor
  always @(posedge clk) begin
    if (rst_n && cmdDone) begin
      expItem_t e;
      @(negedge clk);
      if (expQ.size() == 0) begin
        testsFailed++;
        $display("FAIL R4 no expected item actual=0 expected=1");
      end else begin
        e = expQ.pop_front();
        chk("R4 irq pulse", irqPulse, e.irq);
        chk("R4 branch pulse", branchTaken, e.br);
        chk("R5 bit after done", brStatusBit, e.br);
        chk("R7 no wait after done", waitReq, 1'b0);
        @(negedge clk);
        chk("R4 irq single cycle", irqPulse, 1'b0);
        chk("R4 branch single cycle", branchTaken, 1'b0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    testsFailed++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    for (int s = 0; s < 3; s++) begin shMask[s] = 0; shVal[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq reset", irqPulse, 1'b0);
    chk("R1 branch reset", branchTaken, 1'b0);
    chk("R1 wait reset", waitReq, 1'b0);
    chk("R1 bit reset", brStatusBit, 1'b0);
    // R1 all conditions true after reset
    runCmd(2'd1, 2'd1, 2'd1, 8'hA5, 3);
    repeat (2) @(negedge clk);

    // R2 / R3 interrupt selector pattern
    writeSel(2'd0, 8'hF0, 8'hA0);
    runCmd(2'd1, 2'd0, 2'd0, 8'hA5, 2);
    runCmd(2'd1, 2'd0, 2'd0, 8'h5A, 2);
    runCmd(2'd2, 2'd2, 2'd0, 8'h5A, 2);
    // R2 branch selector independent of interrupt one
    writeSel(2'd1, 8'h0F, 8'h05);
    runCmd(2'd1, 2'd1, 2'd0, 8'hA5, 2);
    runCmd(2'd1, 2'd1, 2'd0, 8'hA4, 2);
    runCmd(2'd2, 2'd2, 2'd0, 8'hA4, 2);
    // R3 never / always with non-matching status
    runCmd(2'd0, 2'd3, 2'd3, 8'h00, 2);
    runCmd(2'd3, 2'd0, 2'd0, 8'h00, 2);

    // R5 bit holds while idle
    runCmd(2'd0, 2'd3, 2'd0, 8'h00, 1);
    repeat (4) @(negedge clk);
    chk("R5 bit holds idle", brStatusBit, 1'b1);
    runCmd(2'd0, 2'd0, 2'd0, 8'h00, 1);
    chk("R5 bit stays clear", brStatusBit, 1'b0);

    // R6 code 3 writes nothing
    writeSel(2'd3, 8'hFF, 8'h00);
    runCmd(2'd1, 2'd1, 2'd1, 8'hA5, 2);

    // R6 write in same cycle as completion uses old contents
    @(negedge clk);
    cmdIntCode = 2'd1; cmdBrCode = 2'd0; cmdWaitCode = 2'd0; devStatus = 8'hA5;
    cmdStart = 1;
    @(negedge clk);
    cmdStart = 0;
    @(negedge clk);
    expQ.push_back('{irq: decide(2'd1, 0, 8'hA5), br: 1'b0});
    cmdDone = 1; selWrEn = 1; selWrSel = 2'd0; selWrMask = 8'hFF; selWrValue = 8'h00;
    @(negedge clk);
    cmdDone = 0; selWrEn = 0;
    shMask[0] = 8'hFF; shVal[0] = 8'h00;
    // R6 new contents seen by the next command
    runCmd(2'd1, 2'd0, 2'd0, 8'hA5, 1);
    runCmd(2'd1, 2'd0, 2'd0, 8'h00, 1);

    // R7 wait follows status and releases
    writeSel(2'd2, 8'h03, 8'h01);
    @(negedge clk);
    cmdIntCode = 2'd0; cmdBrCode = 2'd0; cmdWaitCode = 2'd1; devStatus = 8'h01;
    cmdStart = 1;
    @(negedge clk);
    cmdStart = 0;
    @(negedge clk);
    chk("R7 wait asserted", waitReq, 1'b1);
    devStatus = 8'h02;
    @(negedge clk);
    chk("R7 wait released", waitReq, 1'b0);
    devStatus = 8'h05;
    @(negedge clk);
    chk("R7 wait reasserted", waitReq, 1'b1);
    expQ.push_back('{irq: 1'b0, br: 1'b0});
    cmdDone = 1;
    @(negedge clk);
    cmdDone = 0;
    repeat (3) @(negedge clk);
    chk("R7 no wait when idle", waitReq, 1'b0);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule